// File: doc/BRIEF.md
# Monte Carlo Portfolio Satisfaction Evaluator

This block scores one candidate portfolio allocation against a batch of simulated market scenarios. For each scenario it forms the objective value as the dot product of the allocation weights with that scenario's market vector. All security products are formed in parallel, so one scenario is reduced per clock. The objective value then passes through a risk-aversion utility that is selected per run: a quadratic form or a negative exponential. The block sums the utilities and divides by the scenario count, which gives the satisfaction score.

Scenarios come either from an external stream with a valid strobe or from an internal 32-bit pseudo-random generator. The generator is reseeded at every run, so a run repeats exactly. The risk-tolerance parameter is supplied as its reciprocal, so the datapath needs no divider. A running best-score register keeps the highest satisfaction seen since reset. A search engine around the block can use it while it steps through allocations.

All data values are signed fixed point with 8 fractional bits (Q8.8 in 16 bits). The reciprocal of the tolerance parameter is unsigned Q8.8.

Top module: `mc_satisfaction`

## Requirements
- R1: After reset, busy, sat_valid, sat_out and best_out are all 0.
- R2: A start pulse while busy is low captures alloc, recip_zeta, util_sel and src_sel, and raises busy on the next edge. Later changes to these inputs do not affect the run. A start pulse while busy is high is ignored and leaves the running result unchanged.
- R3: For one scenario, the objective is psi = (sum over j of alloc_j * market_j) arithmetically shifted right by 8. It is then saturated to the signed 16-bit range [-32768, 32767]. Element j occupies bits [16j+15:16j] of each vector.
- R4: With util_sel = 0, the utility is u = psi - floor(psi*psi*r / 2^17), where r is recip_zeta.
- R5: With util_sel = 1, let x = floor(psi*r / 2^8), clamped to [0, 2047]. Let K_k = round(256*e^-k) for k = 0..8, let i = x >> 8, and let f = x & 255. The utility is then u = -(K_i + floor((K_(i+1) - K_i)*f / 256)), which is never positive.
- R6: After 16 utilities have been accumulated, sat_out = floor(sum / 16). In the same cycle sat_valid pulses high for exactly one cycle and busy goes low.
- R7: With src_sel = 1, scenarios come from a Galois generator. It is seeded with 0x00000001 at each accepted start, and each step is s = (s >> 1) XOR (s[0] ? 0x80200003 : 0). Scenario n uses the state after n steps. Market element j is bits [8j+15:8j] of {s, s}, with the 8j offset taken modulo 32. One scenario is used per cycle, and sat_valid rises on the 17th rising edge after the edge that accepts start.
- R8: With src_sel = 0, a market vector is consumed only on edges where busy and scen_valid are both high and fewer than 16 scenarios have been taken. Beats while idle, and beats after the 16th, have no effect. Gaps in the stream are allowed.
- R9: At the end of each run, best_out takes the new satisfaction if this is the first run since reset or if the new value is greater, compared as signed numbers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run (accepted when idle) |
| alloc | input | 64 | Allocation weights, 4 x signed Q8.8 |
| recip_zeta | input | 16 | Reciprocal of the risk tolerance, unsigned Q8.8 |
| util_sel | input | 1 | 0 selects quadratic utility, 1 selects exponential utility |
| src_sel | input | 1 | 0 selects the external scenario stream, 1 selects the internal generator |
| scen_valid | input | 1 | External scenario strobe |
| scen_market | input | 64 | External market vector, 4 x signed Q8.8 |
| busy | output | 1 | Run in progress |
| sat_valid | output | 1 | One-cycle pulse: sat_out is new |
| sat_out | output | 50 | Averaged satisfaction, signed Q8 |
| best_out | output | 50 | Highest satisfaction since reset, signed |

## Verification
The final accumulation of a run and a new start request can fall in the same clock. The bench provokes this by asserting start, with a different allocation, in exactly the cycle in which the sixteenth utility is summed. It also provokes a similar overlap mid-run. It judges the result by requiring that the score equals the model of the original run, that busy stays low afterwards and that no second done pulse appears. In external mode, extra scenario beats are kept valid while the scenario count fills, and again before start is accepted, to show that they are never consumed.

// File: rtl/mc_satisfaction.sv
module mc_satisfaction #(
  parameter int NS = 4,
  parameter int W = 16,
  parameter int FRAC = 8,
  parameter int LOG2_N = 4,
  parameter logic [31:0] SEED = 32'h0000_0001,
  localparam int UW = 3*W + 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [NS*W-1:0]      alloc,
  input  logic [W-1:0]         recip_zeta,
  input  logic                 util_sel,
  input  logic                 src_sel,
  input  logic                 scen_valid,
  input  logic [NS*W-1:0]      scen_market,
  output logic                 busy,
  output logic                 sat_valid,
  output logic signed [UW-1:0] sat_out,
  output logic signed [UW-1:0] best_out
);
  localparam int N  = 1 << LOG2_N;
  localparam int CW = LOG2_N + 1;
  localparam int PW = 2*W + $clog2(NS);
  localparam int AW = UW + LOG2_N;
  localparam logic signed [PW-1:0] PSI_HI = PW'((1 << (W-1)) - 1);
  localparam logic signed [PW-1:0] PSI_LO = ~PSI_HI;
  localparam logic signed [2*W:0]  XMAX   = (2*W+1)'((8 << FRAC) - 1);

  logic [NS*W-1:0]       alloc_q;
  logic [W-1:0]          rz_q;
  logic                  sel_q, src_q, pv, have_best;
  logic [31:0]           lfsr;
  logic [CW-1:0]         taken, done_cnt;
  logic signed [AW-1:0]  acc, acc_nx;
  logic signed [W-1:0]   psi_q, psi_n;
  logic [NS*W-1:0]       mkt;
  logic signed [PW-1:0]  dsum, dsh;
  logic                  take;

  function automatic logic [W-1:0] pick(logic [31:0] s, int sh);
    logic [63:0] d;
    d = {s, s};
    return d[sh +: W];
  endfunction

  function automatic int knot(int k);
    int q;
    case (k)
      0: q = 65536;  1: q = 24110;  2: q = 8869;
      3: q = 3263;   4: q = 1200;   5: q = 442;
      6: q = 162;    7: q = 60;     default: q = 22;
    endcase
    return (q + (1 << (15 - FRAC))) >> (16 - FRAC);
  endfunction

  for (genvar j = 0; j < NS; j++) begin : g_mkt
    assign mkt[j*W +: W] = src_q ? pick(lfsr, (8*j) % 32) : scen_market[j*W +: W];
  end

  assign take = busy && (taken < CW'(N)) && (src_q || scen_valid);

  always_comb begin
    dsum = '0;
    for (int j = 0; j < NS; j++)
      dsum = dsum + PW'($signed(alloc_q[j*W +: W])) * PW'($signed(mkt[j*W +: W]));
  end

  assign dsh   = dsum >>> FRAC;
  assign psi_n = (dsh > PSI_HI) ? PSI_HI[W-1:0] : (dsh < PSI_LO) ? PSI_LO[W-1:0] : dsh[W-1:0];

  logic signed [2*W-1:0] sq;
  logic signed [3*W:0]   qt, qsh;
  logic signed [2*W:0]   xp, xs;
  logic [FRAC+2:0]       xc;
  logic signed [UW-1:0]  uq, ue, u_val;
  int                    k_lo, k_hi, term;

  assign sq  = (2*W)'(psi_q) * (2*W)'(psi_q);
  assign qt  = (3*W+1)'(sq) * (3*W+1)'($signed({1'b0, rz_q}));
  assign qsh = qt >>> (2*FRAC + 1);
  assign uq  = UW'(psi_q) - UW'(qsh);
  assign xp  = (2*W+1)'(psi_q) * (2*W+1)'($signed({1'b0, rz_q}));
  assign xs  = xp >>> FRAC;

  always_comb begin
    if (xs[2*W])        xc = '0;
    else if (xs > XMAX) xc = XMAX[FRAC+2:0];
    else                xc = xs[FRAC+2:0];
    k_lo = knot(int'(xc[FRAC+2:FRAC]));
    k_hi = knot(int'(xc[FRAC+2:FRAC]) + 1);
    term = ((k_hi - k_lo) * int'(xc[FRAC-1:0])) >>> FRAC;
    ue   = UW'(-(k_lo + term));
  end

  assign u_val  = sel_q ? ue : uq;
  assign acc_nx = acc + AW'(u_val);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0;  sat_valid <= 1'b0;  sat_out <= '0;  best_out <= '0;
      have_best <= 1'b0;  alloc_q <= '0;  rz_q <= '0;  sel_q <= 1'b0;
      src_q <= 1'b0;  lfsr <= SEED;  taken <= '0;  done_cnt <= '0;
      acc <= '0;  pv <= 1'b0;  psi_q <= '0;
    end else begin
      sat_valid <= 1'b0;
      if (start && !busy) begin
        busy <= 1'b1;  alloc_q <= alloc;  rz_q <= recip_zeta;
        sel_q <= util_sel;  src_q <= src_sel;  lfsr <= SEED;
        taken <= '0;  done_cnt <= '0;  acc <= '0;  pv <= 1'b0;
      end else begin
        pv <= take;
        if (take) begin
          psi_q <= psi_n;
          taken <= taken + 1'b1;
          if (src_q) lfsr <= (lfsr >> 1) ^ (lfsr[0] ? 32'h8020_0003 : 32'h0);
        end
        if (pv) begin
          acc <= acc_nx;
          done_cnt <= done_cnt + 1'b1;
          if (done_cnt == CW'(N - 1)) begin
            sat_out   <= UW'(acc_nx >>> LOG2_N);
            sat_valid <= 1'b1;
            busy      <= 1'b0;
            have_best <= 1'b1;
            if (!have_best || UW'(acc_nx >>> LOG2_N) > best_out)
              best_out <= UW'(acc_nx >>> LOG2_N);
          end
        end
      end
    end
  end

  // R6
  pulse_once_chk: assert property (@(posedge clk) disable iff (!rst_n) sat_valid |=> !sat_valid);
  // R6
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n) sat_valid |-> !busy);
  // R2
  run_start_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> $past(start));
  // R8
  take_cap_chk: assert property (@(posedge clk) disable iff (!rst_n) taken <= CW'(N));
  // R5
  exp_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pv && sel_q) |-> (u_val[UW-1] || u_val == '0));
  // R9
  best_mono_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (have_best && $past(have_best)) |-> best_out >= $past(best_out));
endmodule

// File: tb/test_mc_satisfaction.sv
module test_mc_satisfaction;
  logic clk = 0, rst_n = 0, start = 0, util_sel = 0, src_sel = 0, scen_valid = 0;
  logic [63:0] alloc = '0, scen_market = '0;
  logic [15:0] recip_zeta = '0;
  logic busy, sat_valid;
  logic signed [49:0] sat_out, best_out;
  int total = 0, bad = 0, wd = 0;
  longint best_m = 0;
  bit have_m = 0;

  mc_satisfaction i_mc_satisfaction (.*);

  always #10 clk = ~clk;

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      total++; bad++;
      $display("FAIL watchdog act=%0d exp=<150000", wd);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(string tag, longint act, longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  function automatic longint psi_m(logic [63:0] a, logic [63:0] m);
    longint s = 0;
    for (int j = 0; j < 4; j++)
      s += longint'($signed(a[j*16 +: 16])) * longint'($signed(m[j*16 +: 16]));
    s = s >>> 8;
    if (s > 32767) s = 32767;
    if (s < -32768) s = -32768;
    return s;
  endfunction

  function automatic longint kn(longint k);
    return longint'($rtoi($exp(-real'(k)) * 256.0 + 0.5));
  endfunction

  function automatic longint util_m(longint p, longint r, logic sel);
    longint x, i, f;
    if (!sel) return p - ((p * p * r) >>> 17);
    x = (p * r) >>> 8;
    if (x < 0) x = 0;
    if (x > 2047) x = 2047;
    i = x >> 8; f = x & 255;
    return -(kn(i) + (((kn(i + 1) - kn(i)) * f) >>> 8));
  endfunction

  function automatic logic [31:0] lfsr_nx(logic [31:0] s);
    return (s >> 1) ^ (s[0] ? 32'h8020_0003 : 32'h0);
  endfunction

  function automatic logic [63:0] mint(logic [31:0] s);
    logic [63:0] d = {s, s}, m;
    for (int j = 0; j < 4; j++) m[j*16 +: 16] = d[(8*j) % 32 +: 16];
    return m;
  endfunction

  function automatic logic [63:0] rnd_alloc();
    logic [63:0] a;
    for (int j = 0; j < 4; j++) a[j*16 +: 16] = 16'($signed($urandom_range(0, 2047)) - 1024);
    return a;
  endfunction

  task automatic do_run(logic [63:0] a, logic [15:0] rz, logic sel, logic src,
                        bit use_fm, logic [63:0] fm, int gap, int poke, string tag);
    logic [63:0] mk[16];
    logic [31:0] s = 32'h1;
    longint accm = 0, exp_sat;
    int n = 0, cyc = 1;
    for (int k = 0; k < 16; k++) begin
      if (src) begin mk[k] = mint(s); s = lfsr_nx(s); end
      else mk[k] = use_fm ? fm : {$urandom, $urandom};
      accm += util_m(psi_m(a, mk[k]), longint'(rz), sel);
    end
    exp_sat = accm >>> 4;
    @(negedge clk);
    start = 1; alloc = a; recip_zeta = rz; util_sel = sel; src_sel = src;
    scen_valid = 1; scen_market = {$urandom, $urandom};
    @(negedge clk);
    start = 0; alloc = rnd_alloc(); recip_zeta = 16'($urandom); util_sel = ~sel;
    while (!sat_valid && cyc < 200) begin
      if (!src) begin
        if (n >= 16) begin scen_valid = 1; scen_market = {$urandom, $urandom}; end
        else if (int'($urandom_range(0, 99)) >= gap) begin
          scen_valid = 1; scen_market = mk[n]; n++;
        end else begin scen_valid = 0; scen_market = {$urandom, $urandom}; end
      end else scen_valid = 0;
      start = (poke != 0 && (cyc == poke || cyc == 5));
      if (start) alloc = rnd_alloc();
      @(negedge clk); cyc++;
    end
    start = 0; scen_valid = 0;
    chk({tag, " R6 done pulse"}, longint'(sat_valid), 1);
    chk({tag, " R6 satisfaction"}, longint'(sat_out), exp_sat);
    chk({tag, " R6 busy low at done"}, longint'(busy), 0);
    if (src) chk({tag, " R7 latency"}, cyc, 18);
    if (!have_m || exp_sat > best_m) best_m = exp_sat;
    have_m = 1;
    chk({tag, " R9 best"}, longint'(best_out), best_m);
    @(negedge clk);
    if (poke != 0) begin
      chk({tag, " R2 late start ignored busy"}, longint'(busy), 0);
      chk({tag, " R2 late start ignored valid"}, longint'(sat_valid), 0);
    end
  endtask

  initial begin
    void'($urandom(1234));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk("R1 busy", longint'(busy), 0);
    chk("R1 valid", longint'(sat_valid), 0);
    chk("R1 sat", longint'(sat_out), 0);
    chk("R1 best", longint'(best_out), 0);
    // R3 R4 unit weights, fixed market
    do_run({4{16'h0100}}, 16'h0080, 0, 0, 1, {16'h0200, 16'hFF00, 16'h0080, 16'h0040}, 20, 0, "quad_fixed");
    // R3 positive saturation
    do_run({4{16'h7FFF}}, 16'h0000, 0, 0, 1, {4{16'h7FFF}}, 0, 0, "sat_hi");
    // R3 negative saturation
    do_run({4{16'h7FFF}}, 16'h0000, 0, 0, 1, {4{16'h8000}}, 0, 0, "sat_lo");
    // R5 clamp at zero (negative objective)
    do_run({4{16'h0100}}, 16'h0100, 1, 0, 1, {4{16'hFF00}}, 10, 0, "exp_neg");
    // R5 clamp at top
    do_run({4{16'h0100}}, 16'hFFFF, 1, 0, 1, {4{16'h4000}}, 10, 0, "exp_top");
    // R5 interpolation mid-range
    do_run({4{16'h0100}}, 16'h0100, 1, 0, 1, {16'h0080, 16'h0100, 16'h0040, 16'h0012}, 0, 0, "exp_mid");
    // R7 R2 internal source with mid-run and final-cycle start
    do_run(rnd_alloc(), 16'h0040, 0, 1, 0, '0, 0, 17, "int_quad");
    do_run(rnd_alloc(), 16'h0200, 1, 1, 0, '0, 0, 17, "int_exp");
    // R8 random external with gaps
    for (int t = 0; t < 8; t++) begin
      logic sel = logic'($urandom_range(0, 1));
      logic src = logic'($urandom_range(0, 1));
      do_run(rnd_alloc(), 16'($urandom_range(1, 1024)), sel, src, 0, '0, 40, src ? 17 : 0, "rand");
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule